// File: doc/BRIEF.md
# External Sync Arm and Trigger Controller

This block decides when the channels of a multi-channel DAC datapath realign. Software can request alignment at once through a sync write strobe. It can also arm the block so that the next rising edge of an external trigger input aligns every channel. The block emits a single-cycle sync pulse that all channel datapaths share.

The armed state can be cancelled by a disarm strobe, and a waiting flag can be read while the block is armed. A manual request strobe drives a one-cycle pulse on an output so that fabric logic can loop it back to the trigger input. The external trigger input is asynchronous: it passes through a synchroniser chain, and only its rising edge is detected. Setting a single parameter removes the whole external path. The software sync strobe keeps working in that case.

All control inputs are single-cycle write strobes that the register decoder produces. Because the block never holds them, they clear themselves.

Top module: `ext_sync_ctrl`

## Requirements
- R1: A sync strobe sampled at a clock edge makes `chan_sync` high for the following cycle. Each request, whether from software or from the trigger, produces a pulse exactly one clock wide.
- R2: With the external path enabled (`EXT_EN`=1), an arm strobe without a disarm strobe sets `trig_wait` to 1 from the next cycle.
- R3: While armed, a rising edge on `ext_sync_in` makes `chan_sync` high in the third cycle after the input rises (two synchroniser flops plus the output register). In that same cycle, `trig_wait` returns to 0.
- R4: A disarm strobe clears `trig_wait` in the next cycle. No sync pulse is issued, and later trigger edges do not fire.
- R5: If arm and disarm strobes arrive in the same cycle, disarm wins and the block stays idle (`trig_wait`=0).
- R6: The trigger reacts to edges, not levels. An input that is already high when the block is armed does not fire. The next low-to-high transition does fire.
- R7: A manual request strobe makes `ext_req_out` high for exactly the next cycle. It does not change `chan_sync` or `trig_wait`.
- R8: With `EXT_EN`=0, arm, disarm and manual request strobes have no effect, and `trig_wait` and `ext_req_out` stay 0. The sync strobe still works as in R1.
- R9: After reset, `chan_sync`, `ext_req_out` and `trig_wait` are all 0.
- R10: A trigger edge that arrives while the block is not armed produces no sync pulse.
- R11: An arm strobe in the same cycle as a trigger firing lets the pulse issue and leaves the block armed again (`trig_wait` stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_sync_wr | input | 1 | Software sync strobe |
| arm_wr | input | 1 | Arm strobe for the external trigger |
| disarm_wr | input | 1 | Disarm strobe |
| man_req_wr | input | 1 | Manual external request strobe |
| ext_sync_in | input | 1 | Asynchronous external trigger |
| chan_sync | output | 1 | One-cycle sync pulse to all channels |
| ext_req_out | output | 1 | One-cycle manual request to fabric |
| trig_wait | output | 1 | High while armed and waiting for a trigger |

## Verification
The hardest cases to reach involve strobes colliding with a trigger edge at the exact cycle the edge leaves the synchroniser. Examples are a re-arm strobe in the firing cycle, and a trigger level that is already high when the block is armed. The directed part of the stimulus counts the cycles from each edge of `ext_sync_in` so that it can place a strobe on that one cycle. A long random phase then mixes trigger toggles with sparse strobes, so that many further collisions occur and each is compared against a behavioural model. A second instance with the external path removed receives the same stimulus.

// File: rtl/ext_sync_ctrl.sv
module ext_sync_ctrl #(
  parameter bit EXT_EN      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_sync_wr,
  input  logic arm_wr,
  input  logic disarm_wr,
  input  logic man_req_wr,
  input  logic ext_sync_in,
  output logic chan_sync,
  output logic ext_req_out,
  output logic trig_wait
);

  logic fire;

  generate
    if (EXT_EN) begin : g_ext
      logic [SYNC_STAGES:0] chain;
      logic armed;
      logic req;
      logic rise;

      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], ext_sync_in};
      end

      assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
      assign fire = armed & rise & ~disarm_wr;

      always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (disarm_wr) armed <= 1'b0;
        else if (arm_wr)    armed <= 1'b1;
        else if (fire)      armed <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= man_req_wr;
      end

      assign trig_wait   = armed;
      assign ext_req_out = req;
    end else begin : g_noext
      assign fire        = 1'b0;
      assign trig_wait   = 1'b0;
      assign ext_req_out = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) chan_sync <= 1'b0;
    else        chan_sync <= sw_sync_wr | fire;
  end

endmodule

// File: rtl/ext_sync_ctrl_chk.sv
module ext_sync_ctrl_chk #(
  parameter bit EXT_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic sw_sync_wr,
  input logic arm_wr,
  input logic disarm_wr,
  input logic man_req_wr,
  input logic chan_sync,
  input logic ext_req_out,
  input logic trig_wait
);

  assert_sync_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sync_wr |=> chan_sync);

  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sync && !$past(sw_sync_wr)) |-> $past(trig_wait));

  assert_disarm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> !trig_wait);

  assert_fall_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trig_wait) && !$past(disarm_wr)) |-> chan_sync);

  assert_manual_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    man_req_wr |=> (ext_req_out == EXT_EN));

  generate
    if (EXT_EN) begin : g_on
      assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && !disarm_wr) |=> trig_wait);
    end else begin : g_off
      assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wait && !ext_req_out);
    end
  endgenerate

endmodule

bind ext_sync_ctrl ext_sync_ctrl_chk #(.EXT_EN(EXT_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_sync_wr(sw_sync_wr), .arm_wr(arm_wr),
  .disarm_wr(disarm_wr), .man_req_wr(man_req_wr), .chan_sync(chan_sync),
  .ext_req_out(ext_req_out), .trig_wait(trig_wait)
);

// File: tb/ext_sync_ctrl_test.sv
`timescale 1ns/1ps
module ext_sync_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_wr = 0, a_wr = 0, d_wr = 0, m_wr = 0, ext = 0;
  logic cs, er, tw, cs0, er0, tw0;
  int total = 0, bad = 0;
  logic running = 1'b0;

  always #10 clk = ~clk;

  ext_sync_ctrl #(.EXT_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sw_sync_wr(s_wr), .arm_wr(a_wr), .disarm_wr(d_wr),
    .man_req_wr(m_wr), .ext_sync_in(ext), .chan_sync(cs), .ext_req_out(er), .trig_wait(tw));
  ext_sync_ctrl #(.EXT_EN(1'b0)) uut_off (
    .clk(clk), .rst_n(rst_n), .sw_sync_wr(s_wr), .arm_wr(a_wr), .disarm_wr(d_wr),
    .man_req_wr(m_wr), .ext_sync_in(ext), .chan_sync(cs0), .ext_req_out(er0), .trig_wait(tw0));

  int hist[$];
  bit m_cs, m_er, m_tw, m0_cs;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cs = 0; m_er = 0; m_tw = 0; m0_cs = 0;
    end else begin
      bit edge_seen, go;
      edge_seen = (hist[hist.size()-2] == 1) && (hist[hist.size()-3] == 0);
      hist.push_back(int'(ext));
      void'(hist.pop_front());
      go = m_tw && edge_seen && !d_wr;
      m_cs = s_wr || go;
      m_er = m_wr;
      if (d_wr) m_tw = 0;
      else if (a_wr) m_tw = 1;
      else if (go) m_tw = 0;
      m0_cs = s_wr;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R1 R3 model chan_sync", cs, m_cs);
      chk("R7 model ext_req_out", er, m_er);
      chk("R2 R4 model trig_wait", tw, m_tw);
      chk("R8 model off chan_sync", cs0, m0_cs);
      chk("R8 model off ext_req_out", er0, 1'b0);
      chk("R8 model off trig_wait", tw0, 1'b0);
    end
  end

  task automatic step(input logic s, input logic a, input logic d, input logic m);
    s_wr = s; a_wr = a; d_wr = d; m_wr = m;
    @(negedge clk);
    s_wr = 0; a_wr = 0; d_wr = 0; m_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset chan_sync", cs, 0);
    chk("R9 reset ext_req_out", er, 0);
    chk("R9 reset trig_wait", tw, 0);
    rst_n = 1'b1;
    running = 1'b1;
    idle(2);

    step(1, 0, 0, 0); chk("R1 sync pulse", cs, 1);
    step(0, 0, 0, 0); chk("R1 one cycle wide", cs, 0);

    ext = 1; idle(4); chk("R10 unarmed edge", cs, 0);
    ext = 0; idle(3);

    step(0, 1, 0, 0); chk("R2 armed", tw, 1);
    ext = 1; idle(2); chk("R3 not yet", cs, 0); chk("R3 still waiting", tw, 1);
    idle(1); chk("R3 fire", cs, 1); chk("R3 waiting cleared", tw, 0);
    idle(1); chk("R1 trigger pulse width", cs, 0);
    ext = 0; idle(3);

    step(0, 1, 0, 0); step(0, 0, 1, 0); chk("R4 disarmed", tw, 0); chk("R4 no sync", cs, 0);
    ext = 1; idle(4); chk("R4 edge after disarm", cs, 0);
    ext = 0; idle(3);

    step(0, 1, 1, 0); chk("R5 disarm wins", tw, 0);
    idle(1);

    ext = 1; idle(3);
    step(0, 1, 0, 0); idle(4); chk("R6 level ignored", cs, 0); chk("R6 still waiting", tw, 1);
    ext = 0; idle(3); ext = 1; idle(3); chk("R6 new edge fires", cs, 1);
    ext = 0; idle(3);

    step(0, 1, 0, 0);
    step(0, 0, 0, 1); chk("R7 request", er, 1); chk("R7 no sync", cs, 0); chk("R7 waiting kept", tw, 1);
    idle(1); chk("R7 request width", er, 0);

    ext = 1; idle(2);
    step(0, 1, 0, 0); chk("R11 fire", cs, 1); chk("R11 rearmed", tw, 1);
    step(0, 0, 1, 0); ext = 0; idle(3);

    step(0, 1, 0, 1); chk("R8 off not armed", tw0, 0); chk("R8 off no request", er0, 0);
    step(1, 0, 1, 0); chk("R8 off sync works", cs0, 1);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) ext = ~ext;
      step($urandom_range(0, 15) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 19) == 0, $urandom_range(0, 15) == 0);
    end

    running = 1'b0;
    finish_run();
  end
endmodule